// File: doc/BRIEF.md
# Integer divide unit with flags

A multi-cycle integer divide and modulo engine for a 64-bit RISC pipeline. It executes signed and unsigned divide, extended divide (the dividend is moved into the upper half of a double-width value) and modulo, each in a doubleword and a word width. The unit returns one quotient bit per cycle and has a fixed latency. It accepts one operation per start pulse, shows busy while it works, then pulses done for one cycle. The result and all flag outputs stay on the ports until the next completion.

Alongside the result, the unit produces a 4-bit condition field for record forms and updated overflow status for overflow-enable forms. The sign and zero tests behind the condition field follow the 32-bit or 64-bit addressing mode of the issuing context. Divide by zero and quotients that do not fit the result width both give a zero result, and they raise overflow when the instruction asks for it.

Top module: `idiv_flags_unit`

## Requirements
- R1: A start sampled while idle is accepted. busy is high from the next cycle until done rises. done is a single-cycle pulse that rises XLEN+1 (65) clock edges after the accepting edge, with busy low while done is high. A start sampled while busy is ignored. After reset busy, done and result are 0.
- R2: op=00 is divide: the quotient of opa by opb, truncated toward zero, signed when signed_op=1 and unsigned otherwise.
- R3: op=01 is extended divide: the dividend is opa placed above a zero half of the operand width. For example, unsigned doubleword 2/3 gives 0xAAAAAAAAAAAAAAAA and 0x8000000000000000 divided by all-ones gives 0x8000000000000000.
- R4: op=10 or 11 is modulo. The signed remainder takes the sign of the dividend (-4329874 mod ±43879 = -29732). The unsigned remainder of a smaller dividend is the dividend itself.
- R5: word_op=1 uses only the low 32 bits of each operand. The 32-bit result is sign-extended for signed operations and zero-extended for unsigned ones.
- R6: A zero divisor (in the selected width) gives result 0 for every operation.
- R7: A divide or extended divide whose quotient does not fit the signed or unsigned range of the width gives result 0. This includes the most negative value divided by -1.
- R8: For a normal completion with ovf_en=1, xer_we pulses with done, ov_out=ov32_out=0 and so_out=so_in. With ovf_en=0, xer_we stays low, ov_out=ov32_out=0 and so_out=so_in.
- R9: On divide by zero or overflow with ovf_en=1, ov_out, ov32_out and so_out are all 1.
- R10: With mode32=0 and a normal completion, cr_val = {LT, GT, EQ, SO}: LT = result bit 63, EQ = the whole result is zero, GT = nonzero with bit 63 clear, SO = so_out.
- R11: With mode32=1 the same rules use result bit 31 and the low 32 bits.
- R12: On divide by zero or overflow, cr_val = {3'b001, so_out}.
- R13: cr_we pulses with done only when rec_form=1, and then cr_mask = 8'h80 (condition field 0 is the most significant mask bit). Otherwise cr_mask is 0.
- R14: result, cr_val, ov_out, ov32_out and so_out hold their values from one completion to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 00 divide, 01 extended divide, 1x modulo |
| signed_op | input | 1 | Signed operands |
| word_op | input | 1 | 32-bit form |
| rec_form | input | 1 | Record form: write the condition field |
| ovf_en | input | 1 | Overflow-enable form: write status |
| mode32 | input | 1 | 32-bit addressing mode for the condition tests |
| so_in | input | 1 | Current summary-overflow status |
| opa | input | 64 | Dividend |
| opb | input | 64 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient or remainder |
| cr_we | output | 1 | Condition field write strobe |
| cr_mask | output | 8 | Field select mask for the condition write |
| cr_val | output | 4 | Condition field {LT, GT, EQ, SO} |
| xer_we | output | 1 | Status write strobe |
| ov_out | output | 1 | Overflow |
| ov32_out | output | 1 | 32-bit overflow |
| so_out | output | 1 | Updated summary overflow |

## Verification
Every result is due exactly 65 clock edges after the edge that accepts start, whatever the operands, and the two write strobes are due in that same cycle only. The bench's reference model counts those edges itself from the accepting edge. It predicts busy, done, the strobes and the held outputs for every cycle. It compares them on each falling edge, so a value that lands a cycle early or late, or that drifts while it should hold, is caught in the cycle where it goes wrong. Fixed values taken from the requirements are also checked after selected operations. These include the extended-divide patterns, the signed remainders, the most-negative-by-minus-one overflow and the mode-dependent condition codes.

// File: rtl/idiv_flags_unit.sv
module idiv_flags_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic            signed_op,
  input  logic            word_op,
  input  logic            rec_form,
  input  logic            ovf_en,
  input  logic            mode32,
  input  logic            so_in,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            cr_we,
  output logic [7:0]      cr_mask,
  output logic [3:0]      cr_val,
  output logic            xer_we,
  output logic            ov_out,
  output logic            ov32_out,
  output logic            so_out
);

  localparam int HALF = XLEN / 2;
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);
  localparam logic [XLEN-1:0] WLIM = XLEN'(1) << (HALF - 1);
  localparam logic [XLEN-1:0] DLIM = XLEN'(1) << (XLEN - 1);
  localparam logic [1:0] OP_DIVX = 2'b01;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] rem_q, quo_q, dvs_q;
  logic            mod_q, sgn_q, word_q, rec_q, oe_q, m32_q, so_q;
  logic            nq_q, nr_q, bad_q, zero_q;

  // operand preparation
  logic [XLEN-1:0] a_ext, b_ext, a_mag, b_mag, hi_in, lo_in;
  logic            a_neg, b_neg;

  always_comb begin
    a_ext = opa;
    b_ext = opb;
    if (word_op) begin
      a_ext = {{HALF{signed_op & opa[HALF-1]}}, opa[HALF-1:0]};
      b_ext = {{HALF{signed_op & opb[HALF-1]}}, opb[HALF-1:0]};
    end
    a_neg = signed_op & a_ext[XLEN-1];
    b_neg = signed_op & b_ext[XLEN-1];
    a_mag = a_neg ? -a_ext : a_ext;
    b_mag = b_neg ? -b_ext : b_ext;
    hi_in = '0;
    lo_in = a_mag;
    if (op == OP_DIVX) begin
      if (word_op) begin
        lo_in = a_mag << HALF;
      end else begin
        hi_in = a_mag;
        lo_in = '0;
      end
    end
  end

  // one restoring step per cycle
  logic [XLEN:0] shifted, trial;
  assign shifted = {rem_q, quo_q[XLEN-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  // result and flag formation
  logic            fit, ovf, so_new, msb, is_zero;
  logic [XLEN-1:0] raw, val;
  logic [3:0]      cr_next;

  always_comb begin
    if (word_q)
      fit = sgn_q ? (nq_q ? (quo_q <= WLIM) : (quo_q < WLIM)) : (quo_q[XLEN-1:HALF] == '0);
    else
      fit = !sgn_q || (nq_q ? (quo_q <= DLIM) : !quo_q[XLEN-1]);
    ovf = zero_q | (!mod_q & (bad_q | !fit));
    raw = mod_q ? (nr_q ? -rem_q : rem_q) : (nq_q ? -quo_q : quo_q);
    if (word_q)
      raw = {{HALF{sgn_q & raw[HALF-1]}}, raw[HALF-1:0]};
    val     = ovf ? '0 : raw;
    so_new  = so_q | (oe_q & ovf);
    msb     = m32_q ? val[HALF-1] : val[XLEN-1];
    is_zero = m32_q ? (val[HALF-1:0] == '0) : (val == '0);
    cr_next = ovf ? {3'b001, so_new} : {msb, !msb & !is_zero, is_zero, so_new};
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      mod_q <= 1'b0;
      sgn_q <= 1'b0;
      word_q <= 1'b0;
      rec_q <= 1'b0;
      oe_q <= 1'b0;
      m32_q <= 1'b0;
      so_q <= 1'b0;
      nq_q <= 1'b0;
      nr_q <= 1'b0;
      bad_q <= 1'b0;
      zero_q <= 1'b0;
      done <= 1'b0;
      result <= '0;
      cr_we <= 1'b0;
      cr_mask <= '0;
      cr_val <= '0;
      xer_we <= 1'b0;
      ov_out <= 1'b0;
      ov32_out <= 1'b0;
      so_out <= 1'b0;
    end else begin
      done <= 1'b0;
      cr_we <= 1'b0;
      cr_mask <= '0;
      xer_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN;
          cnt <= '0;
          rem_q <= hi_in;
          quo_q <= lo_in;
          dvs_q <= b_mag;
          mod_q <= op[1];
          sgn_q <= signed_op;
          word_q <= word_op;
          rec_q <= rec_form;
          oe_q <= ovf_en;
          m32_q <= mode32;
          so_q <= so_in;
          nq_q <= a_neg ^ b_neg;
          nr_q <= a_neg;
          zero_q <= (b_mag == '0);
          bad_q <= (hi_in >= b_mag);
        end
        S_RUN: begin
          rem_q <= trial[XLEN] ? shifted[XLEN-1:0] : trial[XLEN-1:0];
          quo_q <= {quo_q[XLEN-2:0], !trial[XLEN]};
          cnt <= cnt + CW'(1);
          if (cnt == LAST) st <= S_FIN;
        end
        S_FIN: begin
          st <= S_IDLE;
          done <= 1'b1;
          result <= val;
          cr_val <= cr_next;
          cr_we <= rec_q;
          cr_mask <= rec_q ? 8'h80 : 8'h00;
          xer_we <= oe_q;
          ov_out <= oe_q & ovf;
          ov32_out <= oe_q & ovf;
          so_out <= so_new;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R1
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R13
  cr_field0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (done && cr_mask == 8'h80));

  // R8
  xer_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xer_we |-> done);

  // R9
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xer_we && ov_out) |-> (so_out && ov32_out));

  // R12
  ovf_cr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ov_out) |-> (cr_val[3:1] == 3'b001));

  // R14
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

// File: tb/sim_idiv_flags_unit.sv
`timescale 1ns/1ps
module sim_idiv_flags_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic sgn = 1'b0, wrd = 1'b0, rec = 1'b0, oe = 1'b0, m32 = 1'b0, so_i = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic busy, done, cr_we, xer_we, ov_out, ov32_out, so_out;
  logic [63:0] result;
  logic [7:0] cr_mask;
  logic [3:0] cr_val;

  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  idiv_flags_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .signed_op(sgn),
    .word_op(wrd), .rec_form(rec), .ovf_en(oe), .mode32(m32), .so_in(so_i),
    .opa(a), .opb(b), .busy(busy), .done(done), .result(result),
    .cr_we(cr_we), .cr_mask(cr_mask), .cr_val(cr_val), .xer_we(xer_we),
    .ov_out(ov_out), .ov32_out(ov32_out), .so_out(so_out));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference for one operation
  task automatic model_calc(input logic [1:0] o, input bit s, input bit w, input bit m,
                            input bit soin, input bit oen, input logic [63:0] x,
                            input logic [63:0] y, output logic [63:0] res,
                            output logic [3:0] cr, output bit ovf, output bit son,
                            output string tg);
    logic [63:0] xe, ye, xm, ym, v;
    logic [127:0] n, q, rm, lim;
    bit xn, yn, fit, msb, z;
    int wd;
    wd = w ? 32 : 64;
    xe = w ? (s ? {{32{x[31]}}, x[31:0]} : {32'b0, x[31:0]}) : x;
    ye = w ? (s ? {{32{y[31]}}, y[31:0]} : {32'b0, y[31:0]}) : y;
    xn = s && xe[63];
    yn = s && ye[63];
    xm = xn ? -xe : xe;
    ym = yn ? -ye : ye;
    ovf = 0;
    res = '0;
    v = '0;
    if (ym == 0) begin
      ovf = 1;
      tg = "R6";
    end else if (o[1]) begin
      rm = {64'b0, xm} % {64'b0, ym};
      v = rm[63:0];
      if (xn) v = -v;
      tg = w ? "R5" : "R4";
    end else begin
      n = (o == 2'b01) ? ({64'b0, xm} << wd) : {64'b0, xm};
      q = n / {64'b0, ym};
      lim = 128'd1 << (s ? wd - 1 : wd);
      if (s) fit = (xn ^ yn) ? (q <= lim) : (q < lim);
      else   fit = q < lim;
      if (!fit) ovf = 1;
      else begin
        v = q[63:0];
        if (xn ^ yn) v = -v;
      end
      tg = !fit ? "R7" : (w ? "R5" : ((o == 2'b01) ? "R3" : "R2"));
    end
    if (!ovf) res = w ? (s ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]}) : v;
    son = soin | (oen & ovf);
    if (ovf) cr = {3'b001, son};
    else begin
      msb = m ? res[31] : res[63];
      z = m ? (res[31:0] == 0) : (res == 0);
      cr = {msb, !msb && !z, z, son};
    end
  endtask

  // cycle model state (predicts outputs after the next rising edge)
  int m_cnt = 0;
  bit m_busy = 0, m_done = 0, m_crwe = 0, m_xwe = 0, m_ov = 0, m_so = 0;
  logic [63:0] m_res = '0, p_res = '0;
  logic [3:0] m_cr = '0, p_cr = '0;
  bit p_rec = 0, p_oe = 0, p_ovf = 0, p_so = 0;
  string m_tag = "R1", m_crtag = "R10", m_xtag = "R8";
  string p_tag = "R1", p_crtag = "R10", p_xtag = "R8";

  always @(negedge clk) begin
    if (rst_n) begin
      chk({busy, done} == {m_busy, m_done}, "R1", 64'({busy, done}), 64'({m_busy, m_done}), "busy/done");
      chk(result == m_res, m_done ? m_tag : "R14", result, m_res, "result");
      chk(cr_val == m_cr, m_crtag, 64'(cr_val), 64'(m_cr), "cr_val");
      chk(cr_we == m_crwe && cr_mask == (m_crwe ? 8'h80 : 8'h00), "R13",
          64'({cr_we, cr_mask}), 64'({m_crwe, (m_crwe ? 8'h80 : 8'h00)}), "cr strobe/mask");
      chk({xer_we, ov_out, ov32_out, so_out} == {m_xwe, m_ov, m_ov, m_so}, m_xtag,
          64'({xer_we, ov_out, ov32_out, so_out}), 64'({m_xwe, m_ov, m_ov, m_so}), "status");
      m_done = 0;
      m_crwe = 0;
      m_xwe = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          m_done = 1;
          m_res = p_res;
          m_cr = p_cr;
          m_crwe = p_rec;
          m_xwe = p_oe;
          m_ov = p_oe & p_ovf;
          m_so = p_so;
          m_tag = p_tag;
          m_crtag = p_crtag;
          m_xtag = p_xtag;
        end
      end else if (start) begin
        m_cnt = 65;
        m_busy = 1;
        model_calc(op, sgn, wrd, m32, so_i, oe, a, b, p_res, p_cr, p_ovf, p_so, p_tag);
        p_rec = rec;
        p_oe = oe;
        p_crtag = p_ovf ? "R12" : (m32 ? "R11" : "R10");
        p_xtag = p_ovf ? "R9" : "R8";
      end
    end
  end

  task automatic go(input logic [1:0] o, input bit s, input bit w, input bit r, input bit e,
                    input bit m, input bit sn, input logic [63:0] x, input logic [63:0] y,
                    input int waitn);
    @(posedge clk);
    #5;
    op = o; sgn = s; wrd = w; rec = r; oe = e; m32 = m; so_i = sn; a = x; b = y;
    start = 1'b1;
    @(posedge clk);
    #5 start = 1'b0;
    repeat (waitn) @(posedge clk);
    #12;
  endtask

  logic [63:0] pa [7];
  logic [63:0] pb [7];

  initial begin
    pa[0] = 64'd0;                 pb[0] = 64'd0;
    pa[1] = 64'h56789a;            pb[1] = 64'h1234;
    pa[2] = 64'd2;                 pb[2] = 64'd3;
    pa[3] = 64'd31;                pb[3] = 64'd157;
    pa[4] = -64'd4329874;          pb[4] = 64'd43879;
    pa[5] = -64'd4329874;          pb[5] = -64'd43879;
    pa[6] = 64'h8000000000000000;  pb[6] = '1;

    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(busy == 0 && done == 0 && result == 0 && cr_we == 0 && xer_we == 0, "R1",
        result, 64'd0, "reset state");

    // fixed values
    go(2'b01, 0, 0, 0, 0, 0, 0, 64'd2, 64'd3, 66);
    chk(result == 64'hAAAAAAAAAAAAAAAA, "R3", result, 64'hAAAAAAAAAAAAAAAA, "ext 2/3");
    go(2'b01, 0, 0, 0, 0, 0, 0, 64'd31, 64'd157, 66);
    chk(result == 64'h328C3AB35CF15328, "R3", result, 64'h328C3AB35CF15328, "ext 31/157");
    go(2'b01, 0, 0, 0, 0, 0, 0, 64'h8000000000000000, '1, 66);
    chk(result == 64'h8000000000000000, "R3", result, 64'h8000000000000000, "ext msb/ones");
    go(2'b10, 0, 0, 0, 0, 0, 0, 64'h8000000000000000, '1, 66);
    chk(result == 64'h8000000000000000, "R4", result, 64'h8000000000000000, "umod msb/ones");
    go(2'b10, 1, 0, 0, 0, 0, 0, -64'd4329874, 64'd43879, 66);
    chk(result == -64'd29732, "R4", result, -64'd29732, "smod pos divisor");
    go(2'b10, 1, 0, 0, 0, 0, 0, -64'd4329874, -64'd43879, 66);
    chk(result == -64'd29732, "R4", result, -64'd29732, "smod neg divisor");
    go(2'b00, 1, 0, 0, 0, 0, 0, -64'd4329874, 64'd43879, 66);
    chk(result == -64'd98, "R2", result, -64'd98, "signed divide");
    go(2'b00, 0, 0, 0, 0, 0, 0, -64'd4329874, 64'd43879, 66);
    chk(result == 64'h17e5a119b9170, "R2", result, 64'h17e5a119b9170, "unsigned divide");
    go(2'b01, 1, 0, 0, 0, 0, 0, -64'd4329874, 64'd43879, 66);
    chk(result == 64'd0, "R7", result, 64'd0, "ext quotient too wide");
    go(2'b01, 0, 1, 0, 0, 0, 0, 64'hFFFFFFFF00000002, 64'd3, 66);
    chk(result == 64'h00000000AAAAAAAA, "R5", result, 64'h00000000AAAAAAAA, "word ext 2/3");
    go(2'b00, 1, 0, 1, 1, 0, 0, 64'h8000000000000000, '1, 66);
    chk(result == 64'd0, "R7", result, 64'd0, "min by -1");
    chk(ov_out && ov32_out && so_out, "R9", 64'({ov_out, ov32_out, so_out}), 64'b111, "overflow status");
    chk(cr_val == 4'b0011, "R12", 64'(cr_val), 64'b0011, "overflow cr");
    go(2'b00, 0, 0, 1, 1, 0, 1, 64'h56789a, 64'h1234, 66);
    chk(result == 64'h4c0 && !ov_out && so_out, "R8", result, 64'h4c0, "normal oe sticky so");
    chk(cr_val == 4'b0101, "R10", 64'(cr_val), 64'b0101, "positive cr");
    go(2'b00, 1, 0, 1, 0, 0, 0, 64'd5, 64'd0, 66);
    chk(result == 64'd0 && cr_val == 4'b0010, "R6", result, 64'd0, "divide by zero");
    go(2'b00, 0, 1, 1, 0, 1, 0, 64'h80000000, 64'd1, 66);
    chk(result == 64'h80000000 && cr_val == 4'b1000, "R11", 64'(cr_val), 64'b1000, "mode32 cr");
    go(2'b00, 0, 1, 1, 0, 0, 0, 64'h80000000, 64'd1, 66);
    chk(cr_val == 4'b0100, "R10", 64'(cr_val), 64'b0100, "mode64 cr");

    // start while busy is ignored
    go(2'b00, 0, 0, 1, 0, 0, 0, 64'd100, 64'd7, 10);
    a = 64'd999; b = 64'd1; start = 1'b1;
    @(posedge clk);
    #5 start = 1'b0;
    repeat (60) @(posedge clk);
    #12;
    chk(result == 64'd14 && !busy, "R1", result, 64'd14, "start while busy ignored");

    // start in the done cycle is accepted
    go(2'b10, 0, 0, 0, 0, 0, 0, 64'd100, 64'd7, 64);
    go(2'b00, 0, 0, 0, 0, 0, 0, 64'd100, 64'd7, 66);
    chk(result == 64'd14, "R1", result, 64'd14, "back-to-back");

    // sweep
    for (int i = 0; i < 7; i++)
      for (int o = 0; o < 3; o++)
        for (int k = 0; k < 4; k++)
          go(2'(o), k[0], k[1], ((i + o) % 2) == 1, ((i + k) % 2) == 0,
             ((i + o + k) % 2) == 1, (i % 3) == 0, pa[i], pb[i], 66);

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    errs++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule